// File: doc/BRIEF.md
# Flash Page-Latch Programming Controller

This block sits between the write side of an 8-bit processor's external data space and a non-volatile memory array. While a latch-map control input is high, the processor's data writes go into a one-page buffer of column latches instead of normal data memory. The processor can fill any subset of that page, from a single byte up to all of it. Rewriting a byte keeps the newest value.

When the processor issues a launch command, the controller raises a busy flag and walks the loaded bytes in ascending column order. For each one it first asks the array to erase that location and then asks it to program the latched value. Bytes that were never loaded are not touched at all. The target page is the upper address field of the most recent latch write. When the last loaded byte has been programmed, the buffer is empty again and busy drops.

Top module: `flash_page_prog`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, `busy` and `arr_req` are 0 and no latch byte counts as loaded.
- R2: A write (`wr_en`=1) with `latch_map_en`=1 stores `wr_data` into the latch selected by `wr_addr[6:0]` and keeps `dmem_we` at 0. With `latch_map_en`=0 the write sets `dmem_we`=1 in the same cycle and leaves the latches unchanged.
- R3: `arr_page` carries `wr_addr[15:7]` of the most recent accepted latch write.
- R4: After a launch, each loaded byte is handled in ascending column order. First comes an erase request (`arr_op`=0) and then a program request (`arr_op`=1), both with that byte's column on `arr_col`. The program request carries the latched data on `arr_data`.
- R5: No erase or program request is issued for a column that was not loaded.
- R6: `busy` rises in the cycle after an accepted launch and stays 1 until the edge that samples `arr_done` for the last program request. With n loaded bytes and an array answering each request L cycles after it appears, busy lasts 1 + 2·n·(L+1) cycles.
- R7: A launch with no loaded bytes holds `busy` high for exactly one cycle and issues no request.
- R8: Writing the same column twice before a launch programs only the second value.
- R9: While `busy` is 1, latch writes and launch commands are ignored.
- R10: A programmed byte is no longer loaded afterwards, so a second launch with no new writes behaves as an empty launch.
- R11: Once `arr_req` is raised, it stays high and `arr_op`, `arr_col` and `arr_page` stay unchanged until `arr_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| latch_map_en | input | 1 | 1 steers data writes into the column latches |
| wr_en | input | 1 | Data-space write strobe |
| wr_addr | input | 16 | Write address: [6:0] column, [15:7] page |
| wr_data | input | 8 | Write data |
| launch | input | 1 | Start erase/program of the loaded bytes |
| busy | output | 1 | Programming in progress |
| dmem_we | output | 1 | Write enable toward normal data memory |
| arr_req | output | 1 | Request to the array, held until done |
| arr_op | output | 1 | 0 = erase, 1 = program |
| arr_page | output | 9 | Target page |
| arr_col | output | 7 | Target column within the page |
| arr_data | output | 8 | Byte to program |
| arr_done | input | 1 | Array completion, one cycle, only while arr_req is 1 |

## Verification
The properties assume that the array raises `arr_done` only while `arr_req` is high, and for a single cycle per request. The array model in the bench answers each request after a set latency and then drops `arr_done` at once, with latencies of zero and above. The properties also assume that launch and latch writes are not given in the same idle cycle. The bench gives every write and every launch on separate cycles, except for the deliberate writes and launch it issues while busy is high.

// File: rtl/flash_pl_pkg.sv
// Shared types for the page-latch programming controller.
package flash_pl_pkg;

    // Operation code presented to the array.
    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_PROG  = 1'b1
    } arr_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SCAN  = 2'd1,
        SQ_ERASE = 2'd2,
        SQ_PROG  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/fpl_first_set.sv
// Finds the lowest set bit of a vector.
// Assumes: N >= 1. idx_o is 0 when found_o is 0.
module fpl_first_set #(
    parameter int N     = 128,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so that the lowest set bit is the last one assigned.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fpl_latch_buf.sv
// Column latch storage: one data byte and one loaded flag per column.
// Assumes: a write and a clear never target the same column in the same cycle,
// which holds because the top blocks writes while busy.
module fpl_latch_buf #(
    parameter int COLS   = 128,
    parameter int DATA_W = 8,
    parameter int COL_W  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [COL_W-1:0]  clr_col,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic [COLS-1:0]   loaded
);

    logic [DATA_W-1:0] mem [COLS];

    // Data storage: the newest write to a column wins.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_col] <= wr_data;
        end
    end

    // Loaded flags: set on write, cleared after programming or on reset.
    generate
        for (genvar c = 0; c < COLS; c++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    loaded[c] <= 1'b0;
                end else if (wr_en && (wr_col == COL_W'(c))) begin
                    loaded[c] <= 1'b1;
                end else if (clr_en && (clr_col == COL_W'(c))) begin
                    loaded[c] <= 1'b0;
                end
            end
        end
    endgenerate

    // Read port for the byte being programmed.
    assign rd_data = mem[rd_col];

endmodule

// File: rtl/fpl_sequencer.sv
// Erase/program sequencer. It walks the loaded flags in ascending order and
// issues an erase and then a program request per loaded column.
// Assumes: arr_done is a one-cycle pulse that comes only while arr_req is high.
module fpl_sequencer
    import flash_pl_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [COLS-1:0]  loaded,
    input  logic             arr_done,
    output logic             busy,
    output logic             arr_req,
    output arr_op_e          arr_op,
    output logic [COL_W-1:0] cur_col,
    output logic             clr_en
);

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] col_d;
    logic             any_found, rest_found;
    logic [COL_W-1:0] any_idx, rest_idx;
    logic [COLS-1:0]  rest_vec;

    // Loaded set without the column now in progress.
    always_comb begin
        rest_vec          = loaded;
        rest_vec[cur_col] = 1'b0;
    end

    fpl_first_set #(.N(COLS), .IDX_W(COL_W)) u_first_all (
        .vec_i   (loaded),
        .found_o (any_found),
        .idx_o   (any_idx)
    );

    fpl_first_set #(.N(COLS), .IDX_W(COL_W)) u_first_rest (
        .vec_i   (rest_vec),
        .found_o (rest_found),
        .idx_o   (rest_idx)
    );

    // Next-state and next-column selection.
    always_comb begin
        state_d = state_q;
        col_d   = cur_col;
        unique case (state_q)
            SQ_IDLE:  if (launch) state_d = SQ_SCAN;
            SQ_SCAN: begin
                if (any_found) begin
                    state_d = SQ_ERASE;
                    col_d   = any_idx;
                end else begin
                    state_d = SQ_IDLE;
                end
            end
            SQ_ERASE: if (arr_done) state_d = SQ_PROG;
            SQ_PROG: begin
                if (arr_done) begin
                    if (rest_found) begin
                        state_d = SQ_ERASE;
                        col_d   = rest_idx;
                    end else begin
                        state_d = SQ_IDLE;
                    end
                end
            end
            default:  state_d = SQ_IDLE;
        endcase
    end

    // State and column registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cur_col <= '0;
        end else begin
            state_q <= state_d;
            cur_col <= col_d;
        end
    end

    // Decoded outputs.
    assign busy    = (state_q != SQ_IDLE);
    assign arr_req = (state_q == SQ_ERASE) || (state_q == SQ_PROG);
    assign arr_op  = (state_q == SQ_PROG) ? OP_PROG : OP_ERASE;
    assign clr_en  = (state_q == SQ_PROG) && arr_done;

endmodule

// File: rtl/flash_page_prog.sv
// Page-latch programming controller top. It steers mapped writes into the
// column latches, records the page of the newest latch write and runs the
// per-byte erase/program sequence on launch.
// Assumes: ADDR_W > COL_W; the array follows the req/done handshake.
module flash_page_prog
    import flash_pl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_map_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              launch,
    output logic              busy,
    output logic              dmem_we,
    output logic              arr_req,
    output logic              arr_op,
    output logic [PAGE_W-1:0] arr_page,
    output logic [COL_W-1:0]  arr_col,
    output logic [DATA_W-1:0] arr_data,
    input  logic              arr_done
);

    logic                  latch_wr;
    logic                  clr_en;
    logic [PAGE_BYTES-1:0] loaded;
    logic [COL_W-1:0]      cur_col;
    arr_op_e               op_e;
    logic                  launch_ok;

    // Write steering: latches only when mapped and idle; data memory otherwise.
    assign latch_wr  = wr_en && latch_map_en && !busy;
    assign dmem_we   = wr_en && !latch_map_en;
    assign launch_ok = launch && !busy;

    // Page register follows the newest accepted latch write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_page <= '0;
        end else if (latch_wr) begin
            arr_page <= wr_addr[ADDR_W-1:COL_W];
        end
    end

    fpl_latch_buf #(.COLS(PAGE_BYTES), .DATA_W(DATA_W), .COL_W(COL_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (latch_wr),
        .wr_col  (wr_addr[COL_W-1:0]),
        .wr_data (wr_data),
        .clr_en  (clr_en),
        .clr_col (cur_col),
        .rd_col  (cur_col),
        .rd_data (arr_data),
        .loaded  (loaded)
    );

    fpl_sequencer #(.COLS(PAGE_BYTES), .COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch_ok),
        .loaded   (loaded),
        .arr_done (arr_done),
        .busy     (busy),
        .arr_req  (arr_req),
        .arr_op   (op_e),
        .cur_col  (cur_col),
        .clr_en   (clr_en)
    );

    assign arr_op  = op_e;
    assign arr_col = cur_col;

endmodule

// File: rtl/flash_page_prog_chk.sv
// Temporal checks on the controller's ports, bound to every instance of the top.
// Assumes: arr_done only while arr_req is high.
module flash_page_prog_chk #(
    parameter int PAGE_W = 9,
    parameter int COL_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch,
    input logic              busy,
    input logic              arr_req,
    input logic              arr_op,
    input logic [PAGE_W-1:0] arr_page,
    input logic [COL_W-1:0]  arr_col,
    input logic              arr_done
);

    // R11: a pending request holds its fields.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_done |=> arr_req && $stable(arr_op) && $stable(arr_col) && $stable(arr_page));

    // R4: an erase that completes is followed by a program of the same column.
    p_erase_then_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_op && arr_done |=> arr_req && arr_op && $stable(arr_col));

    // R4: after a program completes, any next request targets a higher column.
    p_col_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && arr_op && arr_done |=> !arr_req || (!arr_op && arr_col > $past(arr_col)));

    // R6: an idle launch makes busy rise.
    p_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !busy |=> busy);

    // R6: a request is only ever outstanding while busy.
    p_req_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> busy);

    // R9: the target page cannot change while busy.
    p_page_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arr_page));

endmodule

bind flash_page_prog flash_page_prog_chk #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_chk (.*);

// File: tb/flash_page_prog_tb_top.sv
`timescale 1ns/1ps
module flash_page_prog_tb_top;

    typedef struct packed {
        logic       op;
        logic [8:0] page;
        logic [6:0] col;
        logic [7:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch_map_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        launch = 1'b0;
    logic        busy, dmem_we, arr_req, arr_op;
    logic [8:0]  arr_page;
    logic [6:0]  arr_col;
    logic [7:0]  arr_data;
    logic        arr_done = 1'b0;

    int    n_checks = 0;
    int    n_fail = 0;
    int    lat = 0;
    bit    finished = 1'b0;
    item_t expq[$];
    bit    m_valid [128];
    logic [7:0] m_data [128];
    logic [8:0] m_page = '0;

    always #4 clk = ~clk;

    flash_page_prog dut_i (
        .clk(clk), .rst_n(rst_n), .latch_map_en(latch_map_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .launch(launch), .busy(busy),
        .dmem_we(dmem_we), .arr_req(arr_req), .arr_op(arr_op), .arr_page(arr_page),
        .arr_col(arr_col), .arr_data(arr_data), .arr_done(arr_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor / array model: pop the expected item for each request and answer it.
    initial begin
        forever begin
            @(negedge clk);
            arr_done = 1'b0;
            if (arr_req) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5", "unexpected request col", arr_col, -1);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    check(arr_op == e.op, "R4", "op", arr_op, e.op);
                    check(arr_col == e.col, "R4", "col", arr_col, e.col);
                    check(arr_page == e.page, "R3", "page", arr_page, e.page);
                    if (e.op) check(arr_data == e.data, "R8", "data", arr_data, e.data);
                end
                repeat (lat) @(negedge clk);
                arr_done = 1'b1;
            end
        end
    end

    // Driver: one write, updating the model when it is mapped.
    task automatic wr(input bit map, input logic [15:0] a, input logic [7:0] d);
        latch_map_en = map; wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        check(dmem_we == !map, "R2", "dmem_we", dmem_we, !map);
        @(negedge clk);
        wr_en = 1'b0; latch_map_en = 1'b0;
        if (map) begin
            m_valid[a[6:0]] = 1'b1;
            m_data[a[6:0]]  = d;
            m_page          = a[15:7];
        end
    endtask

    // Driver: push the expected items, launch and measure busy.
    task automatic run(input bit poke, input string req);
        int n = 0;
        int cnt = 0;
        int exp_cnt;
        for (int i = 0; i < 128; i++) begin
            if (m_valid[i]) begin
                expq.push_back('{op: 1'b0, page: m_page, col: 7'(i), data: m_data[i]});
                expq.push_back('{op: 1'b1, page: m_page, col: 7'(i), data: m_data[i]});
                m_valid[i] = 1'b0;
                n++;
            end
        end
        exp_cnt = (n == 0) ? 1 : 1 + 2 * n * (lat + 1);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        while (busy && cnt < 100000) begin
            cnt++;
            if (poke && cnt == 1) begin
                latch_map_en = 1'b1; wr_en = 1'b1; wr_addr = 16'hFFFF; wr_data = 8'h5A;
                launch = 1'b1;
            end else if (cnt == 2) begin
                latch_map_en = 1'b0; wr_en = 1'b0; launch = 1'b0;
            end
            @(negedge clk);
        end
        latch_map_en = 1'b0; wr_en = 1'b0; launch = 1'b0;
        check(cnt == exp_cnt, req, "busy cycles", cnt, exp_cnt);
        check(expq.size() == 0, "R5", "pending expected items", expq.size(), 0);
        check(!arr_req, "R6", "arr_req after busy", arr_req, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin m_valid[i] = 1'b0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!arr_req, "R1", "arr_req after reset", arr_req, 0);
        @(negedge clk);
        // R1/R7: nothing loaded after reset, so the launch is empty.
        run(1'b0, "R7");
        // R2: an unmapped write leaves the latches empty.
        wr(1'b0, 16'h0185, 8'h11);
        run(1'b0, "R2");
        // R4/R5: a scattered subset, loaded out of order, on page 3.
        lat = 0;
        wr(1'b1, {9'd3, 7'd100}, 8'hA1);
        wr(1'b1, {9'd3, 7'd5},   8'hB2);
        wr(1'b1, {9'd3, 7'd2},   8'hC3);
        run(1'b0, "R6");
        // R3/R8: rewrite a column and change the page on the last write.
        lat = 2;
        wr(1'b1, {9'd1, 7'd7},   8'h01);
        wr(1'b1, {9'd1, 7'd7},   8'h77);
        wr(1'b1, {9'd1, 7'd10},  8'h10);
        wr(1'b1, {9'd44, 7'd11}, 8'h2B);
        run(1'b0, "R3");
        // R6: full page, with the lowest and highest column included.
        lat = 0;
        for (int i = 0; i < 128; i++) wr(1'b1, {9'd300, 7'(i)}, 8'(i * 3 + 1));
        run(1'b0, "R6");
        // R9: writes and a launch while busy are ignored.
        lat = 1;
        wr(1'b1, {9'd9, 7'd127}, 8'hE7);
        wr(1'b1, {9'd9, 7'd0},   8'h0E);
        run(1'b1, "R9");
        // R9/R10: the poked column was not loaded and programmed bytes are cleared.
        run(1'b0, "R10");
        check(arr_page == 9'd9, "R9", "page after ignored write", arr_page, 9);
        // R1: reset in the middle of loading clears the loaded flags.
        wr(1'b1, {9'd2, 7'd4}, 8'h44);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_valid[4] = 1'b0;
        m_page = '0;
        check(arr_page == 9'd0, "R1", "page after reset", arr_page, 0);
        run(1'b0, "R1");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule